// File: doc/BRIEF.md
# Sequential-pointer buffer memory

This block is a word-wide memory with two ports. The random port works like an ordinary SRAM. It takes an address, chip enable, output enable, read/write and two byte-lane enables. Its reads are combinational. The sequential port has no address bus. It reads and writes at the location held in an internal pointer, which steps forward on each clock while it is enabled. Software, acting through the random port with the command select raised, programs two address windows, A and B. Each window has a first address and a last address.

A start strobe for a window loads the pointer with that window's first address. Each window has its own end flag. The flag rises on the clock edge at which the pointer takes that window's last address. It stays high until that window's strobe or reset. Each flag is a two-state machine. `FLAG_ARMED` moves to `FLAG_HIT` when the pointer lands on the window's last address and that window's strobe is low. `FLAG_HIT` moves back to `FLAG_ARMED` when that window's strobe is asserted. No other transitions exist.

Top module: `seqbuf_top`

## Requirements
- R1: While `rst_n` is low, the pointer, both end flags and the sequential read register are cleared to zero. The window registers are also cleared to zero.
- R2: With `ra_ce`=1, `ra_we`=1 and `ra_cmd`=0, the memory word at `ra_addr` is written on the clock edge. With `ra_ce`=1, `ra_oe`=1, `ra_we`=0 and `ra_cmd`=0, `ra_rdata` shows the addressed word combinationally. In every other case `ra_rdata` is zero.
- R3: `ra_be[0]` controls bits 7:0 and `ra_be[1]` controls bits 15:8. A write changes only the enabled lanes. A read returns zero in any lane that is not enabled.
- R4: A random-port write with `ra_cmd`=1 writes no memory word. It loads the window register chosen by `ra_addr[1:0]` from the low address-width bits of `ra_wdata`. The codes are: 0 = window A first address, 1 = window A last address, 2 = window B first address, 3 = window B last address.
- R5: On the edge where `sq_go_a` is high, the pointer takes window A's first address. `sq_go_b` does the same for window B. If both strobes are high, `sq_go_a` wins.
- R6: When neither strobe is high, the pointer steps up by one on each edge where `sq_ce` and `sq_adv` are both high. Otherwise it holds its value.
- R7: A step from the all-ones address wraps the pointer to zero.
- R8: On an edge with `sq_ce`=1 and `sq_we`=0, the word at the pointer is captured into the sequential read register. The captured value is the word as it was before that edge's writes. `sq_rdata` shows the register when `sq_oe`=1 and zero otherwise.
- R9: On an edge with `sq_ce`=1 and `sq_we`=1, `sq_wdata` is stored at the pointer address.
- R10: If both ports write the same address on one edge, the stored word is `sq_wdata`, and none of the random-port lanes land.
- R11: `eob_a` rises on the edge at which the pointer's new value equals window A's last address. It stays high until an edge with `sq_go_a` high, which clears it even if the pointer lands on that address again. `eob_b` follows the same rule with window B and `sq_go_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_ce | input | 1 | Random port chip enable |
| ra_oe | input | 1 | Random port output enable |
| ra_we | input | 1 | Random port write (1) / read (0) |
| ra_cmd | input | 1 | Routes random writes to the window registers |
| ra_be | input | DATA_W/8 | Byte-lane enables, bit 0 = low byte |
| ra_addr | input | ADDR_W | Random port address |
| ra_wdata | input | DATA_W | Random port write data |
| ra_rdata | output | DATA_W | Random port read data |
| sq_ce | input | 1 | Sequential port enable |
| sq_we | input | 1 | Sequential write (1) / read (0) |
| sq_oe | input | 1 | Sequential output enable |
| sq_adv | input | 1 | Pointer step enable |
| sq_go_a | input | 1 | Load pointer from window A first address |
| sq_go_b | input | 1 | Load pointer from window B first address |
| sq_wdata | input | DATA_W | Sequential write data |
| sq_rdata | output | DATA_W | Registered sequential read data |
| eob_a | output | 1 | Window A end flag |
| eob_b | output | 1 | Window B end flag |

## Verification
The bench runs a 64-word configuration. It programs window A at every possible first address with a last address three steps later. A flag that compares against the pointer's old value would rise one edge late. Window B is set to straddle the top of the array. A pointer that saturates or fails to wrap would then never reach its last address, and `eob_b` would stay low. The bench also sends colliding writes from both ports to one address and reads that word back. A design with the port priority reversed would return the random-port data. Single-lane writes and reads go after swapped or ignored byte enables. Both strobes are raised together to catch a reversed strobe priority. Repeated reads with `sq_adv` low expose a pointer that drifts when it should hold.

// File: rtl/seqbuf_pkg.sv
package seqbuf_pkg;

    // window register select, decoded from the random-port low address bits
    typedef enum logic [1:0] {
        WIN_FIRST_A = 2'd0,
        WIN_LAST_A  = 2'd1,
        WIN_FIRST_B = 2'd2,
        WIN_LAST_B  = 2'd3
    } win_sel_e;

    // per-window end flag machine
    typedef enum logic {
        FLAG_ARMED = 1'b0,
        FLAG_HIT   = 1'b1
    } flag_state_e;

endpackage

// File: rtl/seqbuf_win_regs.sv
module seqbuf_win_regs
    import seqbuf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] first_a,
    output logic [ADDR_W-1:0] last_a,
    output logic [ADDR_W-1:0] first_b,
    output logic [ADDR_W-1:0] last_b
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_a <= '0;
            last_a  <= '0;
            first_b <= '0;
            last_b  <= '0;
        end else if (wr_en) begin
            unique case (win_sel_e'(sel))
                WIN_FIRST_A: first_a <= wdata;
                WIN_LAST_A:  last_a  <= wdata;
                WIN_FIRST_B: first_b <= wdata;
                WIN_LAST_B:  last_b  <= wdata;
            endcase
        end
    end

    // R4
    last_b_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 2'd3) |=> (last_b == $past(wdata)));

endmodule

// File: rtl/seqbuf_ptr.sv
module seqbuf_ptr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_a,
    input  logic              go_b,
    input  logic              adv,
    input  logic [ADDR_W-1:0] first_a,
    input  logic [ADDR_W-1:0] first_b,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [ADDR_W-1:0] ptr_d
);

    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] PTR_MAX = '1;

    always_comb begin
        if (go_a)
            ptr_d = first_a;
        else if (go_b)
            ptr_d = first_b;
        else if (adv)
            ptr_d = ptr_q + PTR_ONE;
        else
            ptr_d = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else
            ptr_q <= ptr_d;
    end

    // R5
    load_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_a |=> (ptr_q == $past(first_a)));

    // R5
    load_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_b && !go_a) |=> (ptr_q == $past(first_b)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_a && !go_b && !adv) |=> $stable(ptr_q));

    // R7
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!go_a && !go_b && adv && ptr_q == PTR_MAX) |=> (ptr_q == '0));

endmodule

// File: rtl/seqbuf_flag.sv
module seqbuf_flag
    import seqbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic hit,
    output logic flag
);

    flag_state_e st_q;
    flag_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_ARMED: if (!clr && hit) st_d = FLAG_HIT;
            FLAG_HIT:   if (clr)         st_d = FLAG_ARMED;
            default:                     st_d = FLAG_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= FLAG_ARMED;
        else
            st_q <= st_d;
    end

    always_comb begin
        flag = (st_q == FLAG_HIT);
    end

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R11
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag);

endmodule

// File: rtl/seqbuf_mem.sv
module seqbuf_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ra_we,
    input  logic [DATA_W/8-1:0] ra_be,
    input  logic [ADDR_W-1:0]   ra_addr,
    input  logic [DATA_W-1:0]   ra_wdata,
    output logic [DATA_W-1:0]   ra_word,
    input  logic                sq_we,
    input  logic                sq_re,
    input  logic [ADDR_W-1:0]   sq_addr,
    input  logic [DATA_W-1:0]   sq_wdata,
    output logic [DATA_W-1:0]   sq_rq
);

    localparam int LANES = DATA_W / 8;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              collide;
    logic              ra_go;

    always_comb begin
        collide = ra_we && sq_we && (ra_addr == sq_addr);
        ra_go   = ra_we && !collide;
    end

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (ra_go && ra_be[l])
                mem[ra_addr][l*8 +: 8] <= ra_wdata[l*8 +: 8];
        end
        if (sq_we)
            mem[sq_addr] <= sq_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sq_rq <= '0;
        else if (sq_re)
            sq_rq <= mem[sq_addr];
    end

    always_comb begin
        ra_word = mem[ra_addr];
    end

    // R10
    seq_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (collide && ra_be != '0) |=> (mem[$past(sq_addr)] == $past(sq_wdata)));

    // R9
    seq_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sq_we |=> (mem[$past(sq_addr)] == $past(sq_wdata)));

endmodule

// File: rtl/seqbuf_top.sv
module seqbuf_top #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ra_ce,
    input  logic                ra_oe,
    input  logic                ra_we,
    input  logic                ra_cmd,
    input  logic [DATA_W/8-1:0] ra_be,
    input  logic [ADDR_W-1:0]   ra_addr,
    input  logic [DATA_W-1:0]   ra_wdata,
    output logic [DATA_W-1:0]   ra_rdata,
    input  logic                sq_ce,
    input  logic                sq_we,
    input  logic                sq_oe,
    input  logic                sq_adv,
    input  logic                sq_go_a,
    input  logic                sq_go_b,
    input  logic [DATA_W-1:0]   sq_wdata,
    output logic [DATA_W-1:0]   sq_rdata,
    output logic                eob_a,
    output logic                eob_b
);

    localparam int LANES = DATA_W / 8;

    logic              mem_we;
    logic              reg_we;
    logic              rd_en;
    logic              step;
    logic [ADDR_W-1:0] first_a;
    logic [ADDR_W-1:0] last_a;
    logic [ADDR_W-1:0] first_b;
    logic [ADDR_W-1:0] last_b;
    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_d;
    logic [DATA_W-1:0] ra_word;
    logic [DATA_W-1:0] sq_rq;
    logic              hit_a;
    logic              hit_b;

    always_comb begin
        mem_we = ra_ce && ra_we && !ra_cmd;
        reg_we = ra_ce && ra_we && ra_cmd;
        rd_en  = ra_ce && ra_oe && !ra_we && !ra_cmd;
        step   = sq_ce && sq_adv;
        hit_a  = (ptr_d == last_a);
        hit_b  = (ptr_d == last_b);
    end

    seqbuf_win_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .sel     (ra_addr[1:0]),
        .wdata   (ra_wdata[ADDR_W-1:0]),
        .first_a (first_a),
        .last_a  (last_a),
        .first_b (first_b),
        .last_b  (last_b)
    );

    seqbuf_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_a    (sq_go_a),
        .go_b    (sq_go_b),
        .adv     (step),
        .first_a (first_a),
        .first_b (first_b),
        .ptr_q   (ptr_q),
        .ptr_d   (ptr_d)
    );

    seqbuf_flag u_flag_a (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sq_go_a),
        .hit   (hit_a),
        .flag  (eob_a)
    );

    seqbuf_flag u_flag_b (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sq_go_b),
        .hit   (hit_b),
        .flag  (eob_b)
    );

    seqbuf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_we    (mem_we),
        .ra_be    (ra_be),
        .ra_addr  (ra_addr),
        .ra_wdata (ra_wdata),
        .ra_word  (ra_word),
        .sq_we    (sq_ce && sq_we),
        .sq_re    (sq_ce && !sq_we),
        .sq_addr  (ptr_q),
        .sq_wdata (sq_wdata),
        .sq_rq    (sq_rq)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign ra_rdata[l*8 +: 8] = (rd_en && ra_be[l]) ? ra_word[l*8 +: 8] : 8'h00;
    end

    assign sq_rdata = sq_oe ? sq_rq : '0;

    // R8
    sq_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_ce && !sq_we && sq_oe && $stable(sq_oe)) |=> (sq_rdata == sq_rq));

    // R11
    flag_a_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eob_a && !sq_go_a && ptr_d == last_a) |=> eob_a);

endmodule

// File: tb/seqbuf_top_tb.sv
`timescale 1ns/1ps
module seqbuf_top_tb;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ra_ce = 0, ra_oe = 0, ra_we = 0, ra_cmd = 0;
    logic [1:0]    ra_be = 0;
    logic [AW-1:0] ra_addr = 0;
    logic [DW-1:0] ra_wdata = 0;
    logic [DW-1:0] ra_rdata;
    logic          sq_ce = 0, sq_we = 0, sq_oe = 0, sq_adv = 0, sq_go_a = 0, sq_go_b = 0;
    logic [DW-1:0] sq_wdata = 0;
    logic [DW-1:0] sq_rdata;
    logic          eob_a, eob_b;

    int n_total = 0;
    int n_fail  = 0;
    string ph = "R1";

    // reference state
    logic [DW-1:0] m_mem [DEPTH];
    logic [AW-1:0] m_ptr = 0, m_fa_s = 0, m_la = 0, m_fb_s = 0, m_lb = 0;
    logic [DW-1:0] m_sq = 0;
    logic          m_ea = 0, m_eb = 0;

    always #10 clk = ~clk;

    seqbuf_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ra_ce(ra_ce), .ra_oe(ra_oe), .ra_we(ra_we), .ra_cmd(ra_cmd),
        .ra_be(ra_be), .ra_addr(ra_addr), .ra_wdata(ra_wdata), .ra_rdata(ra_rdata),
        .sq_ce(sq_ce), .sq_we(sq_we), .sq_oe(sq_oe), .sq_adv(sq_adv),
        .sq_go_a(sq_go_a), .sq_go_b(sq_go_b), .sq_wdata(sq_wdata), .sq_rdata(sq_rdata),
        .eob_a(eob_a), .eob_b(eob_b)
    );

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", ph, what, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [DW-1:0] er;
        er = '0;
        if (ra_ce && ra_oe && !ra_we && !ra_cmd) begin
            if (ra_be[0]) er[7:0]  = m_mem[ra_addr][7:0];
            if (ra_be[1]) er[15:8] = m_mem[ra_addr][15:8];
        end
        chk("ra_rdata", ra_rdata, er);
        chk("sq_rdata", sq_rdata, sq_oe ? m_sq : '0);
        chk("eob_a", {15'd0, eob_a}, {15'd0, m_ea});
        chk("eob_b", {15'd0, eob_b}, {15'd0, m_eb});
    endtask

    task automatic model_edge();
        logic [AW-1:0] np;
        if (sq_ce && !sq_we) m_sq = m_mem[m_ptr];
        if (ra_ce && ra_we && !ra_cmd && !(sq_ce && sq_we && ra_addr == m_ptr)) begin
            if (ra_be[0]) m_mem[ra_addr][7:0]  = ra_wdata[7:0];
            if (ra_be[1]) m_mem[ra_addr][15:8] = ra_wdata[15:8];
        end
        if (sq_ce && sq_we) m_mem[m_ptr] = sq_wdata;
        if (sq_go_a)               np = m_fa_s;
        else if (sq_go_b)          np = m_fb_s;
        else if (sq_ce && sq_adv)  np = m_ptr + AW'(1);
        else                       np = m_ptr;
        m_ea = sq_go_a ? 1'b0 : (m_ea | (np == m_la));
        m_eb = sq_go_b ? 1'b0 : (m_eb | (np == m_lb));
        if (ra_ce && ra_we && ra_cmd) begin
            case (ra_addr[1:0])
                2'd0: m_fa_s = ra_wdata[AW-1:0];
                2'd1: m_la   = ra_wdata[AW-1:0];
                2'd2: m_fb_s = ra_wdata[AW-1:0];
                default: m_lb = ra_wdata[AW-1:0];
            endcase
        end
        m_ptr = np;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        ra_ce = 0; ra_oe = 0; ra_we = 0; ra_cmd = 0; ra_be = 0;
        sq_ce = 0; sq_we = 0; sq_adv = 0; sq_go_a = 0; sq_go_b = 0;
    endtask

    task automatic rwrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
        idle(); ra_ce = 1; ra_we = 1; ra_addr = a; ra_wdata = d; ra_be = be;
        step(); idle();
    endtask

    task automatic rread(input logic [AW-1:0] a, input logic [1:0] be);
        idle(); ra_ce = 1; ra_oe = 1; ra_addr = a; ra_be = be;
        step(); idle();
    endtask

    task automatic setreg(input logic [1:0] sel, input logic [AW-1:0] v);
        idle(); ra_ce = 1; ra_we = 1; ra_cmd = 1; ra_be = 2'b11;
        ra_addr = AW'(sel); ra_wdata = DW'(v) | 16'hA500;
        step(); idle();
    endtask

    task automatic strobe(input logic a, input logic b);
        idle(); sq_go_a = a; sq_go_b = b; step(); idle();
    endtask

    task automatic run(input int n, input logic adv);
        for (int i = 0; i < n; i++) begin
            idle(); sq_ce = 1; sq_oe = 1; sq_adv = adv; step();
        end
        idle();
    endtask

    initial begin
        #(20 * 200000);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        // R1: reset state
        ph = "R1";
        sq_oe = 1;
        repeat (3) @(negedge clk);
        chk("eob_a in reset", {15'd0, eob_a}, 16'd0);
        chk("eob_b in reset", {15'd0, eob_b}, 16'd0);
        chk("sq_rdata in reset", sq_rdata, 16'd0);
        rst_n = 1'b1;

        // R2: full-word fill and readback, plus disabled reads
        ph = "R2";
        for (int a = 0; a < DEPTH; a++)
            rwrite(AW'(a), (16'(a) * 16'h0101) ^ 16'h5A3C, 2'b11);
        for (int a = 0; a < DEPTH; a++) rread(AW'(a), 2'b11);
        idle(); ra_ce = 1; ra_oe = 0; ra_addr = 7; ra_be = 2'b11; step();
        idle(); ra_ce = 0; ra_oe = 1; ra_addr = 7; ra_be = 2'b11; step();
        idle(); ra_ce = 1; ra_oe = 1; ra_cmd = 1; ra_addr = 7; ra_be = 2'b11; step();

        // R3: single-lane writes and reads
        ph = "R3";
        for (int a = 0; a < 8; a++) begin
            rwrite(AW'(a), 16'hC0DE + 16'(a), 2'b01);
            rwrite(AW'(a), 16'h7E00 + 16'(a * 3), 2'b10);
            rwrite(AW'(a), 16'hFFFF, 2'b00);
            rread(AW'(a), 2'b01);
            rread(AW'(a), 2'b10);
            rread(AW'(a), 2'b00);
            rread(AW'(a), 2'b11);
        end

        // R4: window registers, memory untouched
        ph = "R4";
        setreg(2'd0, 6'd5);
        setreg(2'd1, 6'd12);
        setreg(2'd2, 6'd60);
        setreg(2'd3, 6'd3);
        for (int a = 0; a < 4; a++) rread(AW'(a), 2'b11);

        // R5, R8, R11: window A walk
        ph = "R5";
        strobe(1, 0);
        ph = "R8";
        run(10, 1);
        ph = "R11";
        run(3, 1);

        // R6: hold when not advancing
        ph = "R6";
        run(5, 0);
        idle(); sq_adv = 1; step(); step();
        run(2, 0);

        // R7: window B wraps through the top
        ph = "R7";
        strobe(0, 1);
        run(8, 1);
        run(DEPTH, 1);

        // R5: both strobes together, A wins
        ph = "R5";
        strobe(1, 1);
        run(2, 0);

        // R9: sequential writes walked through window A
        ph = "R9";
        strobe(1, 0);
        for (int i = 0; i < 6; i++) begin
            idle(); sq_ce = 1; sq_we = 1; sq_adv = 1; sq_wdata = 16'hB000 + 16'(i * 17);
            step();
        end
        idle();
        for (int a = 5; a < 11; a++) rread(AW'(a), 2'b11);

        // R10: both ports write one address, then distinct addresses
        ph = "R10";
        strobe(1, 0);
        idle(); sq_ce = 1; sq_we = 1; sq_wdata = 16'h1234;
        ra_ce = 1; ra_we = 1; ra_addr = 5; ra_wdata = 16'hABCD; ra_be = 2'b11;
        step(); idle();
        rread(6'd5, 2'b11);
        idle(); sq_ce = 1; sq_we = 1; sq_wdata = 16'h4321;
        ra_ce = 1; ra_we = 1; ra_addr = 9; ra_wdata = 16'h9876; ra_be = 2'b10;
        step(); idle();
        rread(6'd5, 2'b11);
        rread(6'd9, 2'b11);

        // R11 and R5: every first address, last address three steps on
        ph = "R11";
        for (int s = 0; s < DEPTH; s++) begin
            setreg(2'd0, AW'(s));
            setreg(2'd1, AW'(s + 3));
            strobe(1, 0);
            run(4, 1);
            run(1, 0);
        end
        // R11: strobe clears even when landing on the last address
        setreg(2'd1, 6'd20);
        setreg(2'd0, 6'd20);
        run(1, 1);
        strobe(1, 0);
        run(1, 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule